// File: doc/BRIEF.md
# Sixteen-Phase Interleave Timing Generator

This block drives the shared timing of a time-interleaved converter made of sixteen parallel sections. A single free-running base counter runs on the rising edge of the input clock. Each section's position in its sixteen-cycle schedule is derived from that counter, with section k running exactly one cycle behind section k-1. As a result, exactly one section is in its input-sample slot on any clock, and exactly one section is in its data-transfer slot. The whole pattern repeats every sixteen clocks.

For every section the block outputs the current schedule position as a 4-bit index, together with one-hot sample and transfer strobe vectors. It also times the power-up calibration interval. A calibrated flag rises once 10,000 clock edges have passed since reset was released. The flag holds until the next reset. Because every event comes from a clock edge, calibration only advances while the clock is running.

Top module: `interleave_timer`

## Requirements
- R1: During and right after synchronous active-low reset the base count is 0, so section k reports phase (16-k) mod 16. Section k's index occupies bits [4k+3:4k] of `sect_phase`.
- R2: Every rising clock edge with reset released advances each section's phase by one, modulo 16.
- R3: On every cycle, section k's phase equals section k-1's phase minus one, modulo 16.
- R4: `sample_stb` has exactly one bit set each cycle, and that bit belongs to the section whose phase is 3.
- R5: `xfer_stb` has exactly one bit set each cycle, and that bit belongs to the section whose phase is 15.
- R6: The phases and both strobe vectors repeat exactly with a period of 16 clocks, and the sampling section moves up by one section (wrapping from 15 to 0) on each clock.
- R7: `cal_done` stays 0 until 10,000 rising edges have occurred since reset was released. It is 1 from that edge on.
- R8: Once set, `cal_done` stays 1 until reset. Reset clears it, and the 10,000-edge count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input conversion clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sect_phase | output | 64 | Packed per-section schedule indices, 4 bits per section |
| sample_stb | output | 16 | One-hot: section taking the input sample this cycle |
| xfer_stb | output | 16 | One-hot: section transferring its result this cycle |
| cal_done | output | 1 | Power-up calibration interval elapsed |

## Verification
The schedule is swept cycle by cycle over three full sixteen-clock rotations starting from reset. Each step compares all sixteen phase fields and both strobe vectors against an arithmetic model (base minus section index). This separates an incorrect lag direction, a wrong slot decode and a counter that fails to wrap. The rotations are compared with snapshots taken sixteen clocks earlier to expose any period other than sixteen. The calibration flag is probed on the 9,999th and 10,000th edges after release, which catches an off-by-one in the interval. A reset applied after the flag has risen shows that both the flag and the schedule restart.

// File: rtl/itg_pkg.sv
// Package: default sizing for the interleave timing generator.
// Assumes the schedule length equals the section count and is a power of two.
package itg_pkg;
    localparam int unsigned ITG_PH_W_DEF        = 4;
    localparam int unsigned ITG_CAL_CYCLES_DEF  = 10000;
    localparam int unsigned ITG_SAMPLE_SLOT_DEF = 3;
    localparam int unsigned ITG_XFER_SLOT_DEF   = 15;
endpackage

// File: rtl/itg_phase_ctr.sv
// Module: itg_phase_ctr
// Free-running base counter shared by all sections. It wraps naturally
// at 2**PH_W. Assumes a synchronous active-low reset.
module itg_phase_ctr #(
    parameter int unsigned PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] base_q
);
    // Advance the base count once per rising clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_q + 1'b1;
    end
endmodule

// File: rtl/itg_section.sv
// Module: itg_section
// Per-section schedule decode. The phase is the base count minus the
// section number, so each section lags its lower neighbour by one clock.
// Pure combinational logic that follows the shared counter.
module itg_section #(
    parameter int unsigned PH_W        = 4,
    parameter int unsigned SECT_ID     = 0,
    parameter int unsigned SAMPLE_SLOT = 3,
    parameter int unsigned XFER_SLOT   = 15
) (
    input  logic [PH_W-1:0] base,
    output logic [PH_W-1:0] phase,
    output logic            sample,
    output logic            xfer
);
    localparam logic [PH_W-1:0] OFS  = PH_W'(SECT_ID);
    localparam logic [PH_W-1:0] SMP  = PH_W'(SAMPLE_SLOT);
    localparam logic [PH_W-1:0] XFR  = PH_W'(XFER_SLOT);

    // Derive this section's slot and the two slot strobes.
    always_comb begin
        phase  = base - OFS;
        sample = (phase == SMP);
        xfer   = (phase == XFR);
    end
endmodule

// File: rtl/itg_cal_timer.sv
// Module: itg_cal_timer
// Counts rising edges after reset release and sets a sticky flag on the
// CAL_CYCLES-th edge. The count freezes once the flag is set.
module itg_cal_timer #(
    parameter int unsigned CAL_CYCLES = 10000,
    parameter int unsigned CAL_W      = $clog2(CAL_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_q
);
    localparam logic [CAL_W-1:0] LAST = CAL_W'(CAL_CYCLES - 1);

    logic [CAL_W-1:0] cnt_q;

    // Count edges until the interval ends, then latch the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/interleave_timer.sv
// Module: interleave_timer
// Top level: one shared base counter, 2**PH_W section decoders and the
// power-up calibration timer. Every output changes only on a rising clock edge.
module interleave_timer
    import itg_pkg::*;
#(
    parameter int unsigned PH_W        = ITG_PH_W_DEF,
    parameter int unsigned CAL_CYCLES  = ITG_CAL_CYCLES_DEF,
    parameter int unsigned SAMPLE_SLOT = ITG_SAMPLE_SLOT_DEF,
    parameter int unsigned XFER_SLOT   = ITG_XFER_SLOT_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic [(1<<PH_W)*PH_W-1:0]    sect_phase,
    output logic [(1<<PH_W)-1:0]         sample_stb,
    output logic [(1<<PH_W)-1:0]         xfer_stb,
    output logic                         cal_done
);
    localparam int unsigned SECTIONS = 1 << PH_W;
    localparam int unsigned CAL_W    = $clog2(CAL_CYCLES);

    logic [PH_W-1:0] base;

    itg_phase_ctr #(.PH_W(PH_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_q (base)
    );

    for (genvar k = 0; k < SECTIONS; k++) begin : g_sect
        itg_section #(
            .PH_W        (PH_W),
            .SECT_ID     (k),
            .SAMPLE_SLOT (SAMPLE_SLOT),
            .XFER_SLOT   (XFER_SLOT)
        ) u_sect (
            .base   (base),
            .phase  (sect_phase[k*PH_W +: PH_W]),
            .sample (sample_stb[k]),
            .xfer   (xfer_stb[k])
        );
    end

    itg_cal_timer #(.CAL_CYCLES(CAL_CYCLES), .CAL_W(CAL_W)) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_q (cal_done)
    );
endmodule

// File: rtl/interleave_timer_chk.sv
// Module: interleave_timer_chk
// Property checker bound to interleave_timer. It watches only the top-level
// ports and keeps its own edge counter for the calibration window.
module interleave_timer_chk #(
    parameter int unsigned PH_W       = 4,
    parameter int unsigned CAL_CYCLES = 10000
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [(1<<PH_W)*PH_W-1:0] sect_phase,
    input logic [(1<<PH_W)-1:0]      sample_stb,
    input logic [(1<<PH_W)-1:0]      xfer_stb,
    input logic                      cal_done
);
    localparam int unsigned N = 1 << PH_W;

    logic [31:0] seen_q;

    // Independent count of edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  seen_q <= '0;
        else if (seen_q < CAL_CYCLES) seen_q <= seen_q + 1;
    end

    p_one_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sample_stb) == 1);

    p_one_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(xfer_stb) == 1);

    p_sample_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sample_stb == {$past(sample_stb[N-2:0]), $past(sample_stb[N-1])});

    for (genvar k = 0; k < N; k++) begin : g_prop
        p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> sect_phase[k*PH_W +: PH_W] ==
                     PH_W'($past(sect_phase[k*PH_W +: PH_W]) + 1'b1));
        if (k > 0) begin : g_lag
            p_neighbour_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
                sect_phase[k*PH_W +: PH_W] ==
                PH_W'(sect_phase[(k-1)*PH_W +: PH_W] - 1'b1));
        end
    end

    p_cal_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done == (seen_q >= CAL_CYCLES));

    p_cal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);
endmodule

bind interleave_timer interleave_timer_chk #(
    .PH_W       (PH_W),
    .CAL_CYCLES (CAL_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sect_phase (sect_phase),
    .sample_stb (sample_stb),
    .xfer_stb   (xfer_stb),
    .cal_done   (cal_done)
);

// File: tb/interleave_timer_tb.sv
`timescale 1ns/1ps
module interleave_timer_tb;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*4-1:0] sect_phase;
    logic [N-1:0]  sample_stb;
    logic [N-1:0]  xfer_stb;
    logic          cal_done;

    int errors = 0;
    int checks = 0;
    int n = 0;          // rising edges since reset release
    bit finished = 0;

    logic [N*4-1:0] hist_ph [16];
    logic [N-1:0]   hist_sm [16];

    always #2 clk = ~clk;

    interleave_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sect_phase(sect_phase),
        .sample_stb(sample_stb), .xfer_stb(xfer_stb), .cal_done(cal_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (edge %0d)", req, act, exp, n);
        end
    endtask

    function automatic logic [N*4-1:0] exp_phase(input int cnt);
        logic [N*4-1:0] v;
        for (int k = 0; k < N; k++) v[k*4 +: 4] = 4'((cnt - k) & 15);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_slot(input int cnt, input int slot);
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = (((cnt - k) & 15) == slot);
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible while reset is held
        chk("R1 phase in reset", 64'(sect_phase), 64'(exp_phase(0)));
        chk("R8 cal cleared by reset", 64'(cal_done), 64'd0);
        rst_n = 1'b1;
        n = 0;
    endtask

    task automatic sweep(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            chk("R2/R3 phases", 64'(sect_phase), 64'(exp_phase(n)));
            chk("R4 sample strobe", 64'(sample_stb), 64'(exp_slot(n, 3)));
            chk("R5 transfer strobe", 64'(xfer_stb), 64'(exp_slot(n, 15)));
            chk("R7 cal low early", 64'(cal_done), 64'd0);
            if (n >= 16) begin
                chk("R6 period 16 phases", 64'(sect_phase), 64'(hist_ph[n % 16]));
                chk("R6 period 16 sample", 64'(sample_stb), 64'(hist_sm[n % 16]));
            end
            hist_ph[n % 16] = sect_phase;
            hist_sm[n % 16] = sample_stb;
            step();
        end
    endtask

    initial begin
        do_reset();
        chk("R1 phase after release", 64'(sect_phase), 64'(exp_phase(0)));
        chk("R1 section 1 field", 64'(sect_phase[7:4]), 64'd15);
        sweep(48);
        while (n < 9999) step();
        chk("R7 cal low at 9999", 64'(cal_done), 64'd0);
        chk("R2 phases late", 64'(sect_phase), 64'(exp_phase(n)));
        step();
        chk("R7 cal high at 10000", 64'(cal_done), 64'd1);
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R8 cal sticky", 64'(cal_done), 64'd1);
            chk("R4 sample late", 64'(sample_stb), 64'(exp_slot(n, 3)));
        end
        do_reset();
        sweep(40);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule